// File: doc/BRIEF.md
# Zero-Overhead Loop Micro-Sequencer

This block steps through a 128-word program held in an external read-only store and turns each word into a 16-bit control word for a datapath that lives elsewhere. It has no arithmetic unit. Counted repetition is done in hardware. A FOR word pushes a loop frame onto a frame stack. The frame holds the body start, the body end, the return point and the remaining count. Each time the program counter reaches the end address of the top frame, the sequencer goes back to the start or leaves the loop in that same cycle. So the loop body needs no decrement or branch words. A CALL word uses the same frame with a count of one and a return point just after the call. Any passage of the program can therefore serve as a subroutine, and it needs no return word.

The store is read asynchronously: `pc_o` addresses it and the selected word comes back on `word_i` within the same cycle. A controller state machine has three states. `ST_RUN` executes one word per clock. `ST_STOP` is entered from `ST_RUN` when a HALT word is executed (transition *halt*). `ST_FAULT` is entered from `ST_RUN` when a FOR or CALL finds the frame stack full (transition *overflow*). Both stopped states are left only through reset (transition *restart*), which returns the controller to `ST_RUN` at address 0.

Top module: `loop_sequencer`

## Requirements
- R1: Reset puts the program counter at 0 in `ST_RUN`, with `halted_o` and `fault_o` low, and leaves the frame stack empty, so a FOR or CALL is always accepted as the first word after reset.
- R2: Word layout: opcode in bits 35:33 (0 NOP, 1 FOR, 2 CALL, 3 BNZ, 4 JUMP, 5 HALT; codes 6 and 7 act as NOP); start or target address in bits 32:26; end address in bits 25:19; reserved bits 18:16, where a nonzero value makes the word act as NOP; count or control bits in 15:0. While running, `ctrl_o` equals bits 15:0 of a NOP word and is 0 for every other opcode.
- R3: A NOP that does not sit at the end address of the top frame advances the program counter by one on each clock.
- R4: FOR with count N≥1 runs the words from start to end address exactly N times, back to back with no extra cycles, and then continues at end address + 1.
- R5: A FOR with count 0 runs its body once, the same as a count of 1.
- R6: FOR frames nest. An inner loop runs to completion on every pass of the outer loop.
- R7: CALL runs the passage from its start to its end address once and then resumes at the word after the CALL. The same passage can be called from several places.
- R8: BNZ jumps to its target when `cond_i` is 1 in the cycle it executes, and otherwise behaves as a NOP.
- R9: JUMP moves the program counter to its target on the next clock.
- R10: HALT moves to `ST_STOP`. From then until reset the program counter holds, `halted_o` is 1 and `ctrl_o` is 0.
- R11: A FOR or CALL executed while the stack already holds DEPTH (default 128) frames moves to `ST_FAULT`. There `fault_o` and `halted_o` stay 1 and the program counter holds until reset. With fewer frames the push is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cond_i | input | 1 | Condition flag tested by BNZ |
| word_i | input | 36 | Program word read from the store at `pc_o` |
| pc_o | output | 7 | Program counter, store address |
| ctrl_o | output | 16 | Control word for the external datapath |
| halted_o | output | 1 | Controller is in `ST_STOP` or `ST_FAULT` |
| fault_o | output | 1 | Controller is in `ST_FAULT` |

## Verification
A corrupted frame field or count shows at `pc_o` on the clock after the matching end address. The loop closes one pass early or late, it returns to the wrong word, or the pass to the next outer loop is missed. Every loop, nesting and call scenario therefore compares the full address trace, cycle by cycle. A wrong stack level shows up only when the stack is close to full. For that reason the overflow case checks that the controller is still running 120 pushes in and faulted after 129, and that a reset clears the stack so that a following CALL is accepted.

// File: rtl/lseq_pkg.sv
package lseq_pkg;
    localparam int ADDR_W = 7;
    localparam int ARG_W  = 16;
    localparam int OP_W   = 3;
    localparam int RSV_W  = 3;
    localparam int WORD_W = OP_W + 2 * ADDR_W + RSV_W + ARG_W;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 3'd0,
        OP_FOR  = 3'd1,
        OP_CALL = 3'd2,
        OP_BNZ  = 3'd3,
        OP_JUMP = 3'd4,
        OP_HALT = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_STOP  = 2'd1,
        ST_FAULT = 2'd2
    } state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] start;
        logic [ADDR_W-1:0] fin;
        logic [ADDR_W-1:0] ret;
        logic [ARG_W-1:0]  cnt;
    } frame_t;
endpackage

// File: rtl/lseq_decode.sv
module lseq_decode
    import lseq_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output op_e               op_o,
    output logic [ADDR_W-1:0] tgt_o,
    output logic [ADDR_W-1:0] fin_o,
    output logic [ARG_W-1:0]  arg_o
);
    localparam int OP_LSB  = WORD_W - OP_W;
    localparam int TGT_LSB = OP_LSB - ADDR_W;
    localparam int FIN_LSB = TGT_LSB - ADDR_W;
    localparam int RSV_LSB = FIN_LSB - RSV_W;

    logic [OP_W-1:0]  raw_op;
    logic [RSV_W-1:0] rsv;

    always_comb begin
        raw_op = word_i[OP_LSB +: OP_W];
        rsv    = word_i[RSV_LSB +: RSV_W];
        tgt_o  = word_i[TGT_LSB +: ADDR_W];
        fin_o  = word_i[FIN_LSB +: ADDR_W];
        arg_o  = word_i[0 +: ARG_W];
        // unknown codes and words with reserved bits set fall back to NOP
        if (rsv == '0 && raw_op <= OP_W'(OP_HALT)) begin
            op_o = op_e'(raw_op);
        end else begin
            op_o = OP_NOP;
        end
    end
endmodule

// File: rtl/lseq_stack.sv
module lseq_stack
    import lseq_pkg::*;
#(
    parameter  int DEPTH = 128,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             dec_i,
    input  frame_t           frame_i,
    output frame_t           top_o,
    output logic             empty_o,
    output logic             full_o,
    output logic [LVL_W-1:0] level_o
);
    frame_t           mem [DEPTH];
    logic [LVL_W-1:0] level;
    logic [LVL_W-1:0] below;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] top_idx;

    always_comb begin
        below   = level - LVL_W'(1);
        wr_idx  = level[IDX_W-1:0];
        top_idx = below[IDX_W-1:0];
        top_o   = mem[top_idx];
        empty_o = (level == '0);
        full_o  = (level == LVL_W'(DEPTH));
        level_o = level;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
        end else if (push_i) begin
            level <= level + LVL_W'(1);
        end else if (pop_i) begin
            level <= below;
        end
    end

    // frame storage carries no reset; the level alone says what is valid
    always_ff @(posedge clk) begin
        if (push_i) begin
            mem[wr_idx] <= frame_i;
        end else if (dec_i) begin
            mem[top_idx].cnt <= mem[top_idx].cnt - ARG_W'(1);
        end
    end
endmodule

// File: rtl/lseq_pcgen.sv
module lseq_pcgen
    import lseq_pkg::*;
(
    input  op_e               op_i,
    input  logic [ADDR_W-1:0] tgt_i,
    input  logic [ADDR_W-1:0] fin_i,
    input  logic [ARG_W-1:0]  arg_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic              cond_i,
    input  frame_t            top_i,
    input  logic              empty_i,
    input  logic              full_i,
    output logic [ADDR_W-1:0] nxt_o,
    output logic              push_o,
    output logic              pop_o,
    output logic              dec_o,
    output frame_t            frame_o,
    output logic              stop_o,
    output logic              ovf_o
);
    logic [ADDR_W-1:0] seq_pc;
    logic              at_end;

    always_comb begin
        seq_pc  = pc_i + ADDR_W'(1);
        at_end  = !empty_i && (pc_i == top_i.fin);
        nxt_o   = seq_pc;
        push_o  = 1'b0;
        pop_o   = 1'b0;
        dec_o   = 1'b0;
        stop_o  = 1'b0;
        ovf_o   = 1'b0;
        frame_o = '0;
        unique case (op_i)
            OP_HALT: begin
                nxt_o  = pc_i;
                stop_o = 1'b1;
            end
            OP_JUMP: begin
                nxt_o = tgt_i;
            end
            OP_FOR, OP_CALL: begin
                if (full_i) begin
                    nxt_o = pc_i;
                    ovf_o = 1'b1;
                end else begin
                    push_o        = 1'b1;
                    nxt_o         = tgt_i;
                    frame_o.start = tgt_i;
                    frame_o.fin   = fin_i;
                    // loops leave past their end, calls resume after themselves
                    frame_o.ret   = (op_i == OP_FOR) ? fin_i + ADDR_W'(1) : seq_pc;
                    frame_o.cnt   = (op_i == OP_FOR && arg_i != '0) ? arg_i : ARG_W'(1);
                end
            end
            default: begin
                if (op_i == OP_BNZ && cond_i) begin
                    nxt_o = tgt_i;
                end else if (at_end) begin
                    if (top_i.cnt > ARG_W'(1)) begin
                        dec_o = 1'b1;
                        nxt_o = top_i.start;
                    end else begin
                        pop_o = 1'b1;
                        nxt_o = top_i.ret;
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/loop_sequencer.sv
module loop_sequencer
    import lseq_pkg::*;
#(
    parameter  int DEPTH = 128,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cond_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ARG_W-1:0]  ctrl_o,
    output logic              halted_o,
    output logic              fault_o
);
    state_e            state_q;
    state_e            state_d;
    logic [ADDR_W-1:0] pc_q;
    op_e               op;
    logic [ADDR_W-1:0] tgt;
    logic [ADDR_W-1:0] fin;
    logic [ARG_W-1:0]  arg;
    logic [ADDR_W-1:0] nxt_pc;
    logic              push_req;
    logic              pop_req;
    logic              dec_req;
    logic              stop_req;
    logic              ovf_req;
    logic              running;
    frame_t            frame;
    frame_t            top;
    logic              stk_empty;
    logic              stk_full;
    logic [LVL_W-1:0]  level;

    lseq_decode u_dec (
        .word_i (word_i),
        .op_o   (op),
        .tgt_o  (tgt),
        .fin_o  (fin),
        .arg_o  (arg)
    );

    lseq_pcgen u_pcgen (
        .op_i    (op),
        .tgt_i   (tgt),
        .fin_i   (fin),
        .arg_i   (arg),
        .pc_i    (pc_q),
        .cond_i  (cond_i),
        .top_i   (top),
        .empty_i (stk_empty),
        .full_i  (stk_full),
        .nxt_o   (nxt_pc),
        .push_o  (push_req),
        .pop_o   (pop_req),
        .dec_o   (dec_req),
        .frame_o (frame),
        .stop_o  (stop_req),
        .ovf_o   (ovf_req)
    );

    lseq_stack #(.DEPTH(DEPTH)) u_stack (
        .clk     (clk),
        .rst     (rst),
        .push_i  (push_req & running),
        .pop_i   (pop_req & running),
        .dec_i   (dec_req & running),
        .frame_i (frame),
        .top_o   (top),
        .empty_o (stk_empty),
        .full_o  (stk_full),
        .level_o (level)
    );

    assign running = (state_q == ST_RUN);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (ovf_req) begin
                    state_d = ST_FAULT;
                end else if (stop_req) begin
                    state_d = ST_STOP;
                end
            end
            ST_STOP:  state_d = ST_STOP;
            ST_FAULT: state_d = ST_FAULT;
            default:  state_d = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            if (running) begin
                pc_q <= nxt_pc;
            end
        end
    end

    always_comb begin
        pc_o     = pc_q;
        halted_o = !running;
        fault_o  = (state_q == ST_FAULT);
        ctrl_o   = (running && op == OP_NOP) ? arg : '0;
    end
endmodule

// File: rtl/lseq_checker.sv
module lseq_checker
    import lseq_pkg::*;
#(
    parameter  int DEPTH = 128,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] pc,
    input logic [ARG_W-1:0]  ctrl,
    input logic              halted,
    input logic              fault,
    input op_e               op,
    input logic [ADDR_W-1:0] tgt,
    input logic [LVL_W-1:0]  level
);
    assert_seq_step_R3: assert property (@(posedge clk) disable iff (rst)
        (!halted && op == OP_NOP && level == '0) |=> pc == ADDR_W'($past(pc) + ADDR_W'(1)));

    assert_jump_target_R9: assert property (@(posedge clk) disable iff (rst)
        (!halted && op == OP_JUMP) |=> pc == $past(tgt));

    assert_stop_hold_R10: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc)));

    assert_idle_ctrl_R10: assert property (@(posedge clk) disable iff (rst)
        halted |-> ctrl == '0);

    assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        fault |=> fault);

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(fault) |-> level == LVL_W'(DEPTH));

    assert_level_bound_R11: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));
endmodule

bind loop_sequencer lseq_checker #(.DEPTH(DEPTH)) u_lseq_checker (
    .clk    (clk),
    .rst    (rst),
    .pc     (pc_o),
    .ctrl   (ctrl_o),
    .halted (halted_o),
    .fault  (fault_o),
    .op     (op),
    .tgt    (tgt),
    .level  (level)
);

// File: tb/tb_loop_sequencer.sv
`timescale 1ns/1ps
module tb_loop_sequencer;
    localparam int CLK_HALF = 2.5;
    localparam int WDOG     = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cond = 1'b0;
    logic [35:0] word;
    logic [6:0]  pc;
    logic [15:0] ctrl;
    logic        halted;
    logic        fault;
    logic [35:0] rom [128];

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #(2.5) clk = ~clk;

    assign word = rom[pc];

    loop_sequencer dut (
        .clk      (clk),
        .rst      (rst),
        .cond_i   (cond),
        .word_i   (word),
        .pc_o     (pc),
        .ctrl_o   (ctrl),
        .halted_o (halted),
        .fault_o  (fault)
    );

    function automatic logic [35:0] mk(int op, int a, int b, int arg);
        return {op[2:0], a[6:0], b[6:0], 3'b000, arg[15:0]};
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(string req, int exp_pc);
        @(negedge clk);
        chk(req, pc, exp_pc);
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 128; i++) rom[i] = '0;
    endtask

    task automatic release_reset();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        hold_reset();
        rom[0] = mk(5, 0, 0, 0);
        release_reset();
        chk("R1 pc", pc, 0);
        chk("R1 halted", halted, 0);
        chk("R1 fault", fault, 0);
    endtask

    task automatic t_straight();
        hold_reset();
        rom[0] = mk(0, 0, 0, 16'h00A1);
        rom[1] = mk(0, 0, 0, 16'h05C3);
        rom[2] = mk(5, 0, 0, 16'h7777);
        rom[3] = mk(7, 0, 0, 16'h1234);
        rom[3][17] = 1'b0;
        release_reset();
        chk("R2 ctrl nop", ctrl, 16'h00A1);
        step("R3 seq", 1);
        chk("R2 ctrl nop2", ctrl, 16'h05C3);
        chk("R2 ctrl halt word", ctrl, 16'h05C3);
        step("R3 seq", 2);
        chk("R2 ctrl on halt", ctrl, 0);
        step("R10 hold", 2);
        chk("R10 halted", halted, 1);
        chk("R10 ctrl", ctrl, 0);
        for (int i = 0; i < 4; i++) step("R10 hold", 2);
        // opcode 7 and a reserved bit act as NOP, control bits still emitted
        hold_reset();
        rom[0] = mk(7, 9, 9, 16'h0042);
        rom[1] = mk(4, 9, 0, 16'h0055);
        rom[1][16] = 1'b1;
        rom[2] = mk(5, 0, 0, 0);
        release_reset();
        chk("R2 code7 ctrl", ctrl, 16'h0042);
        step("R2 code7 nop", 1);
        chk("R2 reserved ctrl", ctrl, 16'h0055);
        step("R2 reserved nop", 2);
    endtask

    task automatic t_for();
        hold_reset();
        rom[0] = mk(1, 1, 2, 3);
        rom[1] = mk(0, 0, 0, 16'h0011);
        rom[2] = mk(0, 0, 0, 16'h0022);
        rom[3] = mk(5, 0, 0, 0);
        release_reset();
        chk("R2 ctrl for", ctrl, 0);
        step("R4 loop", 1);
        step("R4 loop", 2);
        step("R4 loop", 1);
        chk("R4 body ctrl", ctrl, 16'h0011);
        step("R4 loop", 2);
        step("R4 loop", 1);
        step("R4 loop", 2);
        step("R4 exit", 3);
        step("R4 stop", 3);
        chk("R4 halted", halted, 1);
    endtask

    task automatic t_zero_count();
        hold_reset();
        rom[0] = mk(1, 1, 1, 0);
        rom[1] = mk(0, 0, 0, 0);
        rom[2] = mk(5, 0, 0, 0);
        release_reset();
        step("R5 body", 1);
        step("R5 once", 2);
        hold_reset();
        rom[0] = mk(1, 1, 1, 1);
        rom[1] = mk(0, 0, 0, 0);
        rom[2] = mk(5, 0, 0, 0);
        release_reset();
        step("R4 count1 body", 1);
        step("R4 count1 exit", 2);
    endtask

    task automatic t_nest();
        int exp_seq [13] = '{1,2,3,2,3,4,1,2,3,2,3,4,5};
        hold_reset();
        rom[0] = mk(1, 1, 4, 2);
        rom[1] = mk(1, 2, 3, 2);
        rom[2] = mk(0, 0, 0, 0);
        rom[3] = mk(0, 0, 0, 0);
        rom[4] = mk(0, 0, 0, 0);
        rom[5] = mk(5, 0, 0, 0);
        release_reset();
        foreach (exp_seq[i]) step("R6 nest", exp_seq[i]);
        step("R6 stop", 5);
    endtask

    task automatic t_call();
        int exp_seq [6] = '{4,5,1,4,5,2};
        hold_reset();
        rom[0] = mk(2, 4, 5, 99);
        rom[1] = mk(2, 4, 5, 7);
        rom[2] = mk(5, 0, 0, 0);
        rom[4] = mk(0, 0, 0, 16'h0400);
        rom[5] = mk(0, 0, 0, 16'h0500);
        release_reset();
        foreach (exp_seq[i]) step("R7 call", exp_seq[i]);
        step("R7 stop", 2);
    endtask

    task automatic t_branch();
        hold_reset();
        rom[0] = mk(0, 0, 0, 0);
        rom[1] = mk(3, 0, 0, 0);
        rom[2] = mk(5, 0, 0, 0);
        cond = 1'b1;
        release_reset();
        step("R8 seq", 1);
        step("R8 taken", 0);
        step("R8 seq", 1);
        cond = 1'b0;
        step("R8 not taken", 2);
    endtask

    task automatic t_jump();
        hold_reset();
        rom[0] = mk(4, 9, 0, 0);
        rom[9] = mk(5, 0, 0, 0);
        release_reset();
        chk("R2 ctrl jump", ctrl, 0);
        step("R9 jump", 9);
        step("R10 stop", 9);
        chk("R10 halted", halted, 1);
    endtask

    task automatic t_overflow();
        hold_reset();
        rom[0] = mk(2, 0, 0, 0);
        release_reset();
        repeat (120) @(negedge clk);
        chk("R11 below depth", fault, 0);
        chk("R11 running", halted, 0);
        repeat (20) @(negedge clk);
        chk("R11 fault", fault, 1);
        chk("R11 halted", halted, 1);
        chk("R11 pc hold", pc, 0);
        chk("R11 ctrl", ctrl, 0);
        // reset must leave an empty stack: a CALL right away is accepted
        hold_reset();
        rom[0] = mk(2, 5, 5, 0);
        rom[1] = mk(5, 0, 0, 0);
        rom[5] = mk(0, 0, 0, 0);
        release_reset();
        chk("R1 fault cleared", fault, 0);
        step("R1 stack empty", 5);
        chk("R1 no fault", fault, 0);
        step("R1 return", 1);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WDOG && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, WDOG);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_straight();
        t_for();
        t_zero_count();
        t_nest();
        t_call();
        t_branch();
        t_jump();
        t_overflow();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule